// File: doc/BRIEF.md
# Byte-Lane Bus Interface for a 16-Bit Memory Bus

This block connects a byte-oriented execution unit to a byte-addressed external memory bus that is 16 bits wide. The execution unit hands over one request at a time: a byte address (16 or 24 bits, set by a parameter), a size flag that selects byte or word, a direction flag and write data. It then stalls until the block raises a one-cycle completion pulse. For reads, the result comes with that pulse.

The block turns each request into one or two bus cycles. Each cycle drives a word address, an active-low upper-lane enable and a low address bit that together select the byte lanes. It routes write data onto the correct lanes and pulls read bytes off them. A word at an odd address straddles two memory words. The block fetches or stores it in two cycles and joins the two halves, so the execution unit never has to deal with alignment. A ready input from the memory side stretches each bus cycle for as long as it is needed.

Top module: `byte_lane_biu`

## Requirements
- R1: After reset and while idle, no bus cycle is active (`bus_cyc` low), `req_done` is low, `bus_bhe_n` is 1 and `bus_a0` is 0.
- R2: A word request at an even address takes exactly one bus cycle. That cycle has `bus_waddr` = address/2, `bus_bhe_n`=0 and `bus_a0`=0, and moves all 16 bits (D[15:8] = byte at address+1, D[7:0] = byte at address).
- R3: A word request at an odd address A takes two bus cycles. The first has `bus_waddr`=A/2, `bus_bhe_n`=0 and `bus_a0`=1 (upper lane). The second has `bus_waddr`=((A+1) mod 2^ADDR_W)/2, `bus_bhe_n`=1 and `bus_a0`=0 (lower lane). A cycle that uses only the lower lane is always the last cycle of its request.
- R4: Lane code (`bus_bhe_n`,`bus_a0`): (0,0) selects both lanes, (0,1) selects only D[15:8] for an odd byte, and (1,0) selects only D[7:0] for an even byte. The code (1,1) never appears.
- R5: A byte read returns the addressed byte in `req_rdata[7:0]` with `req_rdata[15:8]`=0. An odd address reads from D[15:8] and an even address from D[7:0].
- R6: Write data on `bus_dout`:
  - An aligned word is driven unchanged.
  - A byte write places the byte on both lanes.
  - A misaligned word places its low byte on both lanes in the first cycle and its high byte on both lanes in the second.
  - A read cycle drives 0, and `bus_we` equals the request's write flag during the cycle.
- R7: While `bus_cyc` is high and `bus_rdy` is low, the cycle stays active, and address, lane code, `bus_we` and `bus_dout` do not change.
- R8: `req_done` is a one-cycle pulse in the cycle after `bus_rdy` is sampled high in the last bus cycle, and no bus cycle is active while it is high. For a misaligned word read, `req_rdata[7:0]` comes from the first cycle's D[15:8] and `req_rdata[15:8]` from the second cycle's D[7:0].
- R9: A request is taken only when the block is idle. `req_valid` asserted while a request is in progress is ignored and causes no bus cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_addr | input | ADDR_W | Byte address of the request |
| req_word | input | 1 | 1 = word, 0 = byte |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data (byte in [7:0]) |
| req_done | output | 1 | One-cycle completion pulse |
| req_rdata | output | 16 | Read result, valid with `req_done` |
| bus_cyc | output | 1 | Bus cycle active |
| bus_waddr | output | ADDR_W-1 | Word address |
| bus_a0 | output | 1 | Low address bit of lane code |
| bus_bhe_n | output | 1 | Upper-lane enable, active low |
| bus_we | output | 1 | Write cycle |
| bus_dout | output | 16 | Write data on the lanes |
| bus_din | input | 16 | Read data from the lanes |
| bus_rdy | input | 1 | Memory ready, ends the current cycle |

## Verification
The assertions assume that `bus_rdy` may rise at any time and is meaningful only while `bus_cyc` is high. They also assume that the execution unit can keep `req_valid` high while the block is busy. The bench's memory responder varies its wait count from zero to several cycles, so both immediate and delayed completions occur. It also strobes `req_valid` with an unrelated address in the middle of requests. Apart from that, the bench waits for each completion pulse before it presents the next request.

// File: rtl/byte_lane_biu.sv
module byte_lane_biu #(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_word,
  input  logic              req_write,
  input  logic [15:0]       req_wdata,
  output logic              req_done,
  output logic [15:0]       req_rdata,
  output logic              bus_cyc,
  output logic [ADDR_W-2:0] bus_waddr,
  output logic              bus_a0,
  output logic              bus_bhe_n,
  output logic              bus_we,
  output logic [15:0]       bus_dout,
  input  logic [15:0]       bus_din,
  input  logic              bus_rdy
);

  typedef enum logic [1:0] {S_IDLE, S_FIRST, S_SECOND} state_t;

  state_t            st;
  logic [ADDR_W-1:0] addr_q;
  logic              word_q, we_q;
  logic [15:0]       wd_q;
  logic              done_q;
  logic [15:0]       rdata_q;

  logic              in_first, in_second, split;
  logic [ADDR_W-1:0] cur_addr;

  assign in_first  = (st == S_FIRST);
  assign in_second = (st == S_SECOND);
  assign split     = word_q & addr_q[0];
  assign cur_addr  = in_second ? addr_q + ADDR_W'(1) : addr_q;

  assign bus_cyc   = in_first | in_second;
  assign bus_waddr = cur_addr[ADDR_W-1:1];
  assign bus_a0    = in_first & addr_q[0];
  assign bus_bhe_n = ~(in_first & (word_q | addr_q[0]));
  assign bus_we    = bus_cyc & we_q;

  always_comb begin
    bus_dout = 16'h0000;
    if (bus_we) begin
      if (in_second)               bus_dout = {wd_q[15:8], wd_q[15:8]};
      else if (word_q & ~addr_q[0]) bus_dout = wd_q;
      else                          bus_dout = {wd_q[7:0], wd_q[7:0]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      addr_q  <= '0;
      word_q  <= 1'b0;
      we_q    <= 1'b0;
      wd_q    <= '0;
      done_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          addr_q <= req_addr;
          word_q <= req_word;
          we_q   <= req_write;
          wd_q   <= req_wdata;
          st     <= S_FIRST;
        end
        S_FIRST: if (bus_rdy) begin
          if (split) begin
            if (!we_q) rdata_q[7:0] <= bus_din[15:8];
            st <= S_SECOND;
          end else begin
            if (!we_q) begin
              if (word_q)         rdata_q <= bus_din;
              else if (addr_q[0]) rdata_q <= {8'h00, bus_din[15:8]};
              else                rdata_q <= {8'h00, bus_din[7:0]};
            end
            done_q <= 1'b1;
            st     <= S_IDLE;
          end
        end
        S_SECOND: if (bus_rdy) begin
          if (!we_q) rdata_q[15:8] <= bus_din[7:0];
          done_q <= 1'b1;
          st     <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_done  = done_q;
  assign req_rdata = rdata_q;

endmodule

// File: rtl/biu_checker.sv
module biu_checker #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_done,
  input logic              bus_cyc,
  input logic [ADDR_W-2:0] bus_waddr,
  input logic              bus_a0,
  input logic              bus_bhe_n,
  input logic              bus_we,
  input logic [15:0]       bus_dout,
  input logic              bus_rdy
);

  assert_lane_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_bhe_n && bus_a0));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cyc && !bus_rdy |=> bus_cyc && $stable(bus_waddr) && $stable(bus_a0) &&
      $stable(bus_bhe_n) && $stable(bus_we) && $stable(bus_dout));

  assert_low_lane_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cyc && bus_rdy && bus_bhe_n |=> !bus_cyc);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_done |=> !req_done);

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_done |-> !bus_cyc);

  assert_done_after_rdy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cyc && bus_rdy && bus_bhe_n |=> req_done);

  assert_idle_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_cyc |-> bus_bhe_n && !bus_a0 && !bus_we);

endmodule

bind byte_lane_biu biu_checker #(.ADDR_W(ADDR_W)) u_biu_checker (
  .clk(clk), .rst_n(rst_n), .req_done(req_done), .bus_cyc(bus_cyc),
  .bus_waddr(bus_waddr), .bus_a0(bus_a0), .bus_bhe_n(bus_bhe_n),
  .bus_we(bus_we), .bus_dout(bus_dout), .bus_rdy(bus_rdy));

// File: tb/test_byte_lane_biu.sv
module test_byte_lane_biu;
  localparam int AW = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic          req_word = 1'b0;
  logic          req_write = 1'b0;
  logic [15:0]   req_wdata = '0;
  logic          req_done;
  logic [15:0]   req_rdata;
  logic          bus_cyc;
  logic [AW-2:0] bus_waddr;
  logic          bus_a0, bus_bhe_n, bus_we;
  logic [15:0]   bus_dout;
  logic [15:0]   bus_din;
  logic          bus_rdy = 1'b0;

  byte_lane_biu #(.ADDR_W(AW)) i_byte_lane_biu (.*);

  always #5 clk = ~clk;

  int total = 0, bad = 0, lat = 0, cnt = 0;
  bit finished = 0;
  logic [7:0]  bmem [256];
  logic [7:0]  rmem [256];
  logic [41:0] expq [$];
  bit          exp_read = 0;
  logic [15:0] exp_rd = '0;

  assign bus_din = {bmem[{bus_waddr[6:0], 1'b1}], bmem[{bus_waddr[6:0], 1'b0}]};

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [41:0] ent(input logic [AW-1:0] a, input bit bhe, input bit a0,
                                      input bit we, input logic [15:0] d);
    return {a[AW-1:1], bhe, a0, we, d};
  endfunction

  always @(posedge clk)
    if (bus_cyc && bus_rdy && bus_we) begin
      if (!bus_bhe_n) bmem[{bus_waddr[6:0], 1'b1}] = bus_dout[15:8];
      if (!bus_a0)    bmem[{bus_waddr[6:0], 1'b0}] = bus_dout[7:0];
    end

  always @(negedge clk) begin
    if (!rst_n) begin
      bus_rdy = 0; cnt = 0;
    end else begin
      if (bus_rdy) begin
        if (expq.size() > 0) void'(expq.pop_front());
        cnt = 0;
      end
      if (bus_cyc) begin
        if (expq.size() == 0)
          chk(0, "R9 bus cycle without request", {22'd0, bus_waddr, bus_bhe_n, bus_a0, bus_we, bus_dout}, 0);
        else
          chk({bus_waddr, bus_bhe_n, bus_a0, bus_we, bus_dout} === expq[0],
              "R2 R3 R4 R6 R7 bus cycle", {bus_waddr, bus_bhe_n, bus_a0, bus_we, bus_dout}, expq[0]);
      end
      if (req_done) begin
        chk(expq.size() == 0, "R8 done before last cycle", expq.size(), 0);
        chk(!bus_cyc, "R8 cycle during done", bus_cyc, 0);
        if (exp_read) chk(req_rdata === exp_rd, "R5 R8 read data", req_rdata, exp_rd);
      end
      bus_rdy = 0;
      if (bus_cyc) begin
        if (cnt >= lat) bus_rdy = 1; else cnt++;
      end else cnt = 0;
    end
  end

  task automatic issue(input logic [AW-1:0] a, input bit word, input bit wr,
                       input logic [15:0] wd, input int l, input bit noise);
    logic [AW-1:0] a1;
    logic [15:0] rd;
    int w;
    a1 = a + 1;
    lat = l;
    if (!word) begin
      expq.push_back(ent(a, !a[0], a[0], wr, wr ? {wd[7:0], wd[7:0]} : 16'h0));
      rd = {8'h00, rmem[a[7:0]]};
      if (wr) rmem[a[7:0]] = wd[7:0];
    end else begin
      if (!a[0]) expq.push_back(ent(a, 0, 0, wr, wr ? wd : 16'h0));
      else begin
        expq.push_back(ent(a, 0, 1, wr, wr ? {wd[7:0], wd[7:0]} : 16'h0));
        expq.push_back(ent(a1, 1, 0, wr, wr ? {wd[15:8], wd[15:8]} : 16'h0));
      end
      rd = {rmem[a1[7:0]], rmem[a[7:0]]};
      if (wr) begin rmem[a[7:0]] = wd[7:0]; rmem[a1[7:0]] = wd[15:8]; end
    end
    exp_read = !wr;
    exp_rd = rd;
    req_valid = 1; req_addr = a; req_word = word; req_write = wr; req_wdata = wd;
    @(negedge clk);
    req_valid = 0;
    if (noise) begin
      req_valid = 1; req_addr = ~a; req_word = 1; req_write = 1;
      @(negedge clk);
      req_valid = 0;
    end
    w = 0;
    while (!req_done && w < 100) begin @(negedge clk); w++; end
    chk(req_done, "R8 request never completed", 0, 1);
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      bmem[i] = 8'(i * 37 + 5);
      rmem[i] = 8'(i * 37 + 5);
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!bus_cyc && !req_done, "R1 idle after reset", {bus_cyc, req_done}, 0);
    chk(bus_bhe_n === 1'b1 && bus_a0 === 1'b0, "R1 lane code idle", {bus_bhe_n, bus_a0}, 2'b10);
    issue(24'h000010, 1, 0, 0, 0, 0);          // R2 aligned read
    issue(24'h000021, 1, 0, 0, 2, 0);          // R3 split read
    issue(24'h000030, 0, 0, 0, 1, 0);          // R5 even byte
    issue(24'h000033, 0, 0, 0, 0, 0);          // R5 odd byte
    issue(24'h000040, 1, 1, 16'hBEEF, 1, 0);   // R6 aligned write
    issue(24'h000040, 1, 0, 0, 0, 0);
    issue(24'h000051, 1, 1, 16'hA55A, 3, 0);   // R6 split write
    issue(24'h000051, 1, 0, 0, 1, 0);
    issue(24'h000062, 0, 1, 16'h0077, 0, 0);   // R6 byte writes
    issue(24'h000063, 0, 1, 16'h0099, 2, 0);
    issue(24'h000062, 1, 0, 0, 0, 0);
    issue(24'hFFFFFF, 1, 0, 0, 1, 0);          // R3 wrap
    issue(24'hFFFFFF, 1, 1, 16'h1234, 0, 0);
    issue(24'hFFFFFF, 1, 0, 0, 0, 0);
    issue(24'h000070, 1, 0, 0, 0, 1);          // R9 noise while busy
    issue(24'h000075, 1, 1, 16'hC3C3, 2, 1);
    issue(24'h000075, 0, 0, 0, 2, 1);
    for (int k = 0; k < 40; k++)
      issue(AW'(k * 29 + 3), k[0], k[1] & k[2], 16'(k * 4099), k % 4, k[3]);
    repeat (3) @(negedge clk);
    chk(!bus_cyc && bus_bhe_n && !bus_a0, "R1 idle between requests", {bus_cyc, bus_bhe_n, bus_a0}, 3'b010);
    for (int i = 0; i < 256; i++)
      chk(bmem[i] === rmem[i], "R6 memory contents", bmem[i], rmem[i]);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule